// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-mapped master for the two-wire PHY management bus. Software configures a clock divider, a framing mode (Clause 22 or Clause 45) and a preamble switch, and then writes a command word that names an operation, a PHY address and a register or device address. Each command write starts exactly one serial frame. The block generates the management clock from the system clock. It drives the data line through separate output, output-enable and input pins, so that the pad cell stays outside the block.

Completion is reported through pending flags. Write and address frames report in the write-data register. Read frames report in the read-data register, which also holds a valid flag for a read whose turnaround the PHY answered correctly. A Clause 45 access is two commands issued by software: an address frame that carries the 16-bit register number from the write-data register, then a write or read frame to the same PHY and device.

The bus is a simple single-cycle write port plus a read port. Read data is registered and appears one clock after the address is presented.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset, enable reads 0, the configuration register reads 0x104 (divider 4, preamble on, Clause 22), both pending flags and the valid flag are 0, and `mdio_oe` and `mdc` are low.
- R2: Register offsets are command 0x00, write data 0x08, read data 0x10, configuration 0x18, enable 0x20. Command fields: operation in bits 1:0, PHY address in bits 12:8, register/device address in bits 20:16. Configuration: divider in bits 7:0, preamble enable in bit 8, Clause 45 mode in bit 12. Enable is bit 0.
- R3: In Clause 22 mode the start field is 01. Operation 0 sends opcode 01 (write) and operation 1 sends opcode 10 (read). The opcode is followed by the PHY address and then the register address, all sent MSB first.
- R4: Write and address frames drive turnaround 1 then 0, followed by the 16 write-data bits MSB first. Write-data bit 16 (pending) is set from the command until the cycle in which the line is released.
- R5: Read frames release the line for both turnaround bits and all 16 data bits, and sample data on rising `mdc`. On completion the read-data register holds the data in bits 15:0, pending (bit 16) cleared and valid (bit 17) set.
- R6: If `mdio_i` is high when the second turnaround bit is sampled, the read completes with valid 0.
- R7: In Clause 45 mode the start field is 00, and operations 0, 1 and 3 send opcodes 00 (address), 01 (write) and 11 (read). Operation 2 is ignored.
- R8: With preamble enabled, a frame starts with 32 driven ones (64 clocks in total). With preamble disabled, the frame is 32 clocks long.
- R9: A command written while either pending flag is set is ignored, and at most one pending flag is ever set.
- R10: While enable is 0, commands are ignored and `mdio_oe` stays low. Clearing enable in the middle of a frame releases the line and clears pending.
- R11: The `mdc` half period is divider+1 system clocks. `mdc` is low when idle, and `mdio_o` changes only while `mdc` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line value from the pad |

## Verification
The assertions assume that the divider is not rewritten while a frame is running, since the half-period counter compares against the live value. They also assume that `mdio_i` is settled at every rising `mdc`. The stimulus writes the configuration register only between frames, polls the pending flags until both clear before reconfiguring, and models the PHY so that it changes `mdio_i` only on falling `mdc` and holds it high whenever it is not answering a read.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_WDAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_RDAT = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_EN   = 6'h20;

  localparam int CMD_PHY_LSB = 8;
  localparam int CMD_REG_LSB = 16;
  localparam int FLAG_PEND   = 16;
  localparam int FLAG_VALID  = 17;
  localparam int CFG_PRE_BIT = 8;
  localparam int CFG_C45_BIT = 12;

  localparam logic [1:0] START_C22 = 2'b01;
  localparam logic [1:0] START_C45 = 2'b00;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = run && (cnt == half_div);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R11: clock parks low once the frame stops
  p_mdc_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic          pre_en,
  input  logic          is_rd,
  input  logic [31:0]   word,
  input  logic          rise,
  input  logic          fall,
  input  logic          mdio_i,
  output logic          busy,
  output logic          mdo,
  output logic          mdoe,
  output logic          done,
  output logic          rd_ok,
  output logic [DW-1:0] rd_data
);
  localparam logic [5:0] POS_HDR  = 6'd32;
  localparam logic [5:0] POS_TA0  = 6'd46;
  localparam logic [5:0] POS_TA1  = 6'd47;
  localparam logic [5:0] POS_DAT  = 6'd48;
  localparam logic [5:0] POS_LAST = 6'd63;

  logic [5:0]    pos;
  logic [31:0]   word_q;
  logic          rd_q;
  logic          ta_bad;
  logic [DW-1:0] shreg;
  logic [5:0]    start_pos;
  logic [5:0]    nxt;

  assign start_pos = pre_en ? 6'd0 : POS_HDR;
  assign nxt       = pos + 6'd1;

  function automatic logic bit_of(input logic [31:0] w, input logic [5:0] p);
    return (p < POS_HDR) ? 1'b1 : w[5'(6'd63 - p)];
  endfunction

  function automatic logic oe_of(input logic rd, input logic [5:0] p);
    return !rd || (p < POS_TA0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdo     <= 1'b0;
      mdoe    <= 1'b0;
      done    <= 1'b0;
      pos     <= '0;
      word_q  <= '0;
      rd_q    <= 1'b0;
      ta_bad  <= 1'b0;
      shreg   <= '0;
      rd_ok   <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
        mdoe <= 1'b0;
        mdo  <= 1'b0;
      end else if (start && !busy) begin
        busy   <= 1'b1;
        word_q <= word;
        rd_q   <= is_rd;
        ta_bad <= 1'b0;
        pos    <= start_pos;
        mdo    <= bit_of(word, start_pos);
        mdoe   <= 1'b1;
      end else if (busy) begin
        if (rise && rd_q) begin
          if (pos == POS_TA1) ta_bad <= mdio_i;
          if (pos >= POS_DAT) shreg <= {shreg[DW-2:0], mdio_i};
        end
        if (fall) begin
          if (pos == POS_LAST) begin
            busy  <= 1'b0;
            mdoe  <= 1'b0;
            mdo   <= 1'b0;
            done  <= 1'b1;
            rd_ok <= rd_q && !ta_bad;
            if (rd_q) rd_data <= shreg;
          end else begin
            pos  <= nxt;
            mdo  <= bit_of(word_q, nxt);
            mdoe <= oe_of(rd_q, nxt);
          end
        end
      end
    end
  end

  // R4: completion leaves the line released and the sequencer idle
  p_done_released_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mdoe && !busy));
  // R10: the line is only driven inside a frame
  p_drive_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
    mdoe |-> busy);
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int DW = 16;

  logic [DIV_W-1:0] cfg_div;
  logic             cfg_pre, cfg_c45, en_q;
  logic [DW-1:0]    wdat_q, rdat_q;
  logic             wr_pend, rd_pend, rd_val;

  logic             cmd_hit, legal, cmd_rd, launch;
  logic [1:0]       opc;
  logic [31:0]      frame_word;
  logic             busy, rise, fall, seq_done, seq_ok;
  logic [DW-1:0]    seq_data;
  logic             unused_bits;

  assign unused_bits = ^bus_wdata[DATA_W-1:21];

  assign cmd_hit = bus_we && (bus_addr == OFF_CMD);

  always_comb begin
    legal  = 1'b1;
    cmd_rd = 1'b0;
    opc    = 2'b00;
    if (cfg_c45) begin
      case (bus_wdata[1:0])
        2'd0:    opc = 2'b00;
        2'd1:    opc = 2'b01;
        2'd3:    begin opc = 2'b11; cmd_rd = 1'b1; end
        default: legal = 1'b0;
      endcase
    end else begin
      case (bus_wdata[1:0])
        2'd0:    opc = 2'b01;
        2'd1:    begin opc = 2'b10; cmd_rd = 1'b1; end
        default: legal = 1'b0;
      endcase
    end
  end

  assign launch     = cmd_hit && en_q && !wr_pend && !rd_pend && legal;
  assign frame_word = {cfg_c45 ? START_C45 : START_C22, opc,
                       bus_wdata[CMD_PHY_LSB +: 5], bus_wdata[CMD_REG_LSB +: 5],
                       2'b10, wdat_q};

  mgmt_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .half_div(cfg_div),
    .mdc(mdc), .rise_tick(rise), .fall_tick(fall)
  );

  mgmt_frame_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .en(en_q), .start(launch), .pre_en(cfg_pre),
    .is_rd(cmd_rd), .word(frame_word), .rise(rise), .fall(fall),
    .mdio_i(mdio_i), .busy(busy), .mdo(mdio_o), .mdoe(mdio_oe),
    .done(seq_done), .rd_ok(seq_ok), .rd_data(seq_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div <= DIV_W'(DIV_RESET);
      cfg_pre <= 1'b1;
      cfg_c45 <= 1'b0;
      en_q    <= 1'b0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      wr_pend <= 1'b0;
      rd_pend <= 1'b0;
      rd_val  <= 1'b0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          OFF_WDAT: wdat_q <= bus_wdata[DW-1:0];
          OFF_CFG: begin
            cfg_div <= bus_wdata[DIV_W-1:0];
            cfg_pre <= bus_wdata[CFG_PRE_BIT];
            cfg_c45 <= bus_wdata[CFG_C45_BIT];
          end
          OFF_EN:   en_q <= bus_wdata[0];
          default: ;
        endcase
      end
      if (launch) begin
        if (cmd_rd) begin
          rd_pend <= 1'b1;
          rd_val  <= 1'b0;
        end else begin
          wr_pend <= 1'b1;
        end
      end
      if (seq_done) begin
        wr_pend <= 1'b0;
        rd_pend <= 1'b0;
        if (rd_pend) begin
          rd_val <= seq_ok;
          rdat_q <= seq_data;
        end
      end
      if (!en_q) begin
        wr_pend <= 1'b0;
        rd_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (bus_addr)
        OFF_WDAT: bus_rdata <= {15'd0, wr_pend, wdat_q};
        OFF_RDAT: bus_rdata <= {14'd0, rd_val, rd_pend, rdat_q};
        OFF_CFG:  bus_rdata <= {19'd0, cfg_c45, 3'd0, cfg_pre, DIV_W'(cfg_div)};
        OFF_EN:   bus_rdata <= {31'd0, en_q};
        default:  bus_rdata <= {31'd0, unused_bits & 1'b0};
      endcase
    end
  end

  // R9: at most one kind of frame outstanding
  p_one_pending_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_pend, rd_pend}));
  // R4: write pending drops only with the line released
  p_release_at_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_pend) |-> !mdio_oe);
  // R6: valid can only appear as a read finishes
  p_valid_at_read_end_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_val) |-> $fell(rd_pend));
  // R10: disabled controller lets go of the line
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !mdio_oe);
  // R11: driven data moves only while the clock is low
  p_mdio_edge_r11: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> !mdc);
endmodule

// File: tb/sim_mgmt_serial_master.sv
`timescale 1ns/1ps
module sim_mgmt_serial_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  typedef struct {
    bit          chk;
    int          nbits;
    logic [63:0] val;
    logic [63:0] drv;
    string       tag;
  } exp_t;

  exp_t sb[$];
  event frame_done;

  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0, cyc = 0;
  int rises = 0, start_r = 0, per = 0;
  time last_rise = 0;
  logic cap_v [64];
  logic cap_oe[64];
  bit cur_pre = 1, cur_rd = 0, cur_ok = 1;
  logic [15:0] cur_resp = '0;

  always #2 clk = ~clk;

  mgmt_serial_master u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL watchdog expired actual %0d expected <150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
    end
  end

  // capture what the master puts on the line at each rising clock
  always @(posedge mdc) begin
    #1;
    cap_v[rises % 64]  = mdio_o;
    cap_oe[rises % 64] = mdio_oe;
    per = int'($time - last_rise);
    last_rise = $time;
    rises++;
  end

  // PHY model: changes its answer on the falling clock
  always @(negedge mdc) begin
    int r, b;
    r = rises - start_r;
    b = cur_pre ? 32 : 0;
    if (cur_rd && r == b + 15)
      mdio_i = cur_ok ? 1'b0 : 1'b1;
    else if (cur_rd && r >= b + 16 && r <= b + 31)
      mdio_i = cur_resp[15 - (r - b - 16)];
    else
      mdio_i = 1'b1;
  end

  // monitor: pop expected frame and compare with captured bits
  always begin
    exp_t e;
    int n, bad;
    @(frame_done);
    e = sb.pop_front();
    if (e.chk) begin
      n = rises - start_r;
      bad = 0;
      for (int k = 0; k < e.nbits; k++) begin
        if (cap_oe[(start_r + k) % 64] !== e.drv[k]) bad++;
        else if (e.drv[k] && cap_v[(start_r + k) % 64] !== e.val[k]) bad++;
      end
      mon_checks++;
      if (n != e.nbits || bad != 0) begin
        mon_fails++;
        $display("FAIL %s frame: actual %0d clocks %0d bad bits expected %0d clocks 0 bad bits",
                 e.tag, n, bad, e.nbits);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] w, r;
    for (int i = 0; i < 5000; i++) begin
      bus_read(6'h08, w);
      bus_read(6'h10, r);
      if (!w[16] && !r[16]) break;
    end
  endtask

  task automatic run_frame(input bit c45, input bit pre, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input bit rd, input bit ok,
                           input logic [15:0] resp, input bit dup, input string tag);
    exp_t e;
    logic [1:0]  opc;
    logic [31:0] body;
    logic [31:0] v;
    int base;
    opc  = c45 ? op : (op == 2'd0 ? 2'b01 : 2'b10);
    body = {c45 ? 2'b00 : 2'b01, opc, phy, rg, 2'b10, wd};
    base = pre ? 32 : 0;
    e.chk = 1; e.tag = tag; e.nbits = base + 32; e.val = '0; e.drv = '0;
    for (int k = 0; k < base; k++) begin e.val[k] = 1'b1; e.drv[k] = 1'b1; end
    for (int k = 0; k < 32; k++) begin
      e.val[base + k] = body[31 - k];
      e.drv[base + k] = !rd || (k < 14);
    end
    bus_write(6'h08, {16'd0, wd});
    cur_pre = pre; cur_rd = rd; cur_ok = ok; cur_resp = resp; start_r = rises;
    sb.push_back(e);
    bus_write(6'h00, {11'd0, rg, 3'd0, phy, 6'd0, op});
    if (dup) bus_write(6'h00, {11'd0, 5'd2, 3'd0, 5'd9, 6'd0, 2'd1});
    if (rd) begin
      bus_read(6'h10, v);
      check(v[16] == 1'b1 && v[17] == 1'b0, {tag, " R5 read pending set"}, v, 32'h0001_0000);
    end else begin
      bus_read(6'h08, v);
      check(v[16] == 1'b1, {tag, " R4 write pending set"}, v, {15'd0, 1'b1, wd});
    end
    wait_idle();
    -> frame_done;
    #1;
  endtask

  initial begin
    logic [31:0] v;
    int r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    bus_read(6'h20, v); check(v == 32'h0, "R1 enable reset", v, 32'h0);
    bus_read(6'h18, v); check(v == 32'h104, "R1 config reset", v, 32'h104);
    bus_read(6'h10, v); check(v == 32'h0, "R1 read-data reset", v, 32'h0);
    check(mdio_oe == 1'b0 && mdc == 1'b0, "R1 line idle", {30'd0, mdc, mdio_oe}, 32'h0);

    bus_write(6'h20, 32'h1);
    bus_write(6'h18, 32'h102);
    // R2 R3 R4 Clause 22 write
    run_frame(0, 1, 2'd0, 5'h13, 5'h0a, 16'hA5C3, 0, 1, 16'h0, 0, "R2 R3 R4 c22 write");
    // R5 Clause 22 read
    run_frame(0, 1, 2'd1, 5'h01, 5'h02, 16'h0, 1, 1, 16'h3C5A, 0, "R3 R5 c22 read");
    bus_read(6'h10, v); check(v == 32'h0002_3C5A, "R5 read result", v, 32'h0002_3C5A);
    check(per == 24, "R11 mdc period div2", per, 24);
    // R6 missing turnaround
    run_frame(0, 1, 2'd1, 5'h04, 5'h11, 16'h0, 1, 0, 16'hFFFF, 0, "R6 bad ta read");
    bus_read(6'h10, v); check(v[17:16] == 2'b00, "R6 valid clear", v, {v[31:18], 2'b00, v[15:0]});

    // R7 Clause 45 sequence
    bus_write(6'h18, 32'h1102);
    run_frame(1, 1, 2'd0, 5'h03, 5'h1e, 16'h8001, 0, 1, 16'h0, 0, "R7 c45 address");
    run_frame(1, 1, 2'd1, 5'h03, 5'h1e, 16'h1234, 0, 1, 16'h0, 0, "R7 c45 write");
    run_frame(1, 1, 2'd3, 5'h03, 5'h1e, 16'h0, 1, 1, 16'hBEEF, 0, "R7 c45 read");
    bus_read(6'h10, v); check(v == 32'h0002_BEEF, "R7 c45 read result", v, 32'h0002_BEEF);
    // R7 op 2 ignored
    r0 = rises;
    bus_write(6'h00, {11'd0, 5'h1e, 3'd0, 5'h03, 6'd0, 2'd2});
    repeat (20) @(negedge clk);
    bus_read(6'h08, v);
    check(rises == r0 && !mdio_oe && !v[16], "R7 op2 ignored", rises - r0, 0);

    // R8 no preamble, R11 faster clock
    bus_write(6'h18, 32'h001);
    run_frame(0, 0, 2'd0, 5'h1f, 5'h00, 16'h0F0F, 0, 1, 16'h0, 0, "R8 no preamble");
    check(per == 16, "R11 mdc period div1", per, 16);
    // R9 second command while pending
    run_frame(0, 0, 2'd0, 5'h02, 5'h07, 16'h5AA5, 0, 1, 16'h0, 1, "R9 duplicate ignored");
    bus_read(6'h10, v); check(v == 32'h0002_BEEF, "R9 read not started", v, 32'h0002_BEEF);

    // R10 disabled
    bus_write(6'h20, 32'h0);
    r0 = rises;
    bus_write(6'h00, {11'd0, 5'h01, 3'd0, 5'h01, 6'd0, 2'd0});
    repeat (30) @(negedge clk);
    bus_read(6'h08, v);
    check(rises == r0 && !mdio_oe && !v[16], "R10 disabled ignores", rises - r0, 0);
    // R10 abort mid-frame
    bus_write(6'h20, 32'h1);
    bus_write(6'h18, 32'h102);
    cur_rd = 0;
    bus_write(6'h00, {11'd0, 5'h01, 3'd0, 5'h01, 6'd0, 2'd0});
    repeat (40) @(negedge clk);
    check(mdio_oe == 1'b1, "R10 frame running", {31'd0, mdio_oe}, 32'h1);
    bus_write(6'h20, 32'h0);
    bus_read(6'h08, v);
    check(!v[16] && !mdio_oe, "R10 abort releases", {v[16], mdio_oe}, 32'h0);

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule